// File: doc/BRIEF.md
# Timer Compare Channel with Pulse Output

This block is one output-compare channel that watches a free-running timestamp counter. Software arms a compare value. When the counter reaches that value, the channel raises an event flag and can request an interrupt. It can also act on an output pin: in one mode the pin changes level, and in the other the pin gives a short high pulse of fixed length.

The compare register has two stages. While one value waits for its match, software can write the value after it. The queued value becomes the active one on the same clock edge that consumes the current match. An interrupt handler can therefore keep a periodic chain going, such as one pulse per second, with no gap between events. The handler queues the event after next and then clears the flag by writing one to it.

Top module: `cmp_chan_top`

## Requirements
- R1: After reset the status register reads 0x00, `irq` and `pin_out` are low, and no compare value is armed. Enabling a mode straight after reset produces no event.
- R2: The status register has these fields. Bit 7 is the event flag and bit 6 is the interrupt enable. Bits 5:2 are the mode. Bit 0 is a request enable that is stored and read back but has no other effect. Bit 1 always reads 0. A written mode is visible on readback in the next cycle.
- R3: The channel detects a match on a clock edge when three things hold: the mode is 0x5 or 0xF, a value is armed, and the counter input equals the active value. After that edge the flag reads 1 and the matched value is consumed.
- R4: Writing the status register with bit 7 set clears the flag. Writing it with bit 7 clear leaves the flag unchanged.
- R5: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R6: In mode 0x5 every match inverts `pin_out`.
- R7: In mode 0xF a match drives `pin_out` high for PULSE_LEN cycles, and then `pin_out` goes low again.
- R8: Mode 0x0 and any mode code other than 0x5 and 0xF produce no match. The flag and the pin do not change, and the armed value stays armed.
- R9: A compare write is masked to CTR_W bits. If nothing is armed, the written value becomes active at once. If a value is already armed, the write fills the next-value buffer. `cmp_rdata` returns the active value.
- R10: On a match with a queued next value, that value becomes active on the same edge, so it matches without any further write.
- R11: Matching uses equality on the masked counter, so an armed value is reached correctly across the counter's wrap from all ones to zero.
- R12: Writing 0x00 to the status register disarms both the active and the next value, and it forces `pin_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_val | input | CTR_W | Timestamp counter value |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register read data |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | DATA_W | Compare value write data |
| cmp_rdata | output | CTR_W | Active compare value |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Channel output pin |

## Verification
The bench builds the channel with an 8-bit counter and a 3-cycle pulse. With these values the wrap from 255 to 0 takes only a few hundred cycles, and a write carrying bits above the counter width shows the masking directly. The short pulse lets the bench count the whole high window and the return to low. The bench drives the counter input itself, one step per cycle, so it knows on which edge each match is due. It then checks the flag on the cycle before that edge and on the cycle after it, which pins down the one-cycle latency and the hand-over to the queued value.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;

    localparam int CSR_W = 8;

    typedef enum logic [3:0] {
        MODE_OFF    = 4'h0,
        MODE_TOGGLE = 4'h5,
        MODE_PULSE  = 4'hF
    } mode_e;

    // Status register image, most significant bit first.
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [3:0] mode;
        logic       rsvd;
        logic       req;
    } csr_t;

    function automatic logic mode_fires(input logic [3:0] m);
        return (m == MODE_TOGGLE) || (m == MODE_PULSE);
    endfunction

    function automatic logic is_all_zero(input logic [CSR_W-1:0] d);
        return d == '0;
    endfunction

endpackage

// File: rtl/cmpch_csr.sv
module cmpch_csr
    import cmpch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic             hit,
    output csr_t             q,
    output logic             clr_all
);

    csr_t w;
    logic unused_rsvd;

    always_comb begin
        w           = csr_t'(wdata);
        unused_rsvd = w.rsvd;
        clr_all     = we && is_all_zero(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (we) begin
                q.ie   <= w.ie;
                q.mode <= w.mode;
                q.req  <= w.req;
                if (w.flag) q.flag <= 1'b0;
            end
            if (hit) q.flag <= 1'b1;
            q.rsvd <= 1'b0;
        end
    end

    // The flag may only rise after a match edge (R3).
    p_flag_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(q.flag) |-> $past(hit));

    // A one written to bit 7 with no concurrent match leaves the flag low (R4).
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we && wdata[7] && !hit)) |-> !q.flag);

endmodule

// File: rtl/cmpch_slots.sv
module cmpch_slots
    import cmpch_pkg::*;
#(
    parameter int CTR_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTR_W-1:0] ctr,
    input  logic [3:0]       mode,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_val,
    input  logic             clr_all,
    output logic             hit,
    output logic [CTR_W-1:0] act_val
);

    logic             act_v, nxt_v;
    logic [CTR_W-1:0] nxt_val;
    logic             act_v_d, nxt_v_d;
    logic [CTR_W-1:0] act_d, nxt_d;

    always_comb begin
        hit     = mode_fires(mode) && act_v && (ctr == act_val);
        act_v_d = act_v;
        act_d   = act_val;
        nxt_v_d = nxt_v;
        nxt_d   = nxt_val;
        // Consume the matched value, promoting a queued one.
        if (hit) begin
            if (nxt_v) begin
                act_d   = nxt_val;
                nxt_v_d = 1'b0;
            end else begin
                act_v_d = 1'b0;
            end
        end
        // New writes land after promotion.
        if (wr_en) begin
            if (!act_v_d) begin
                act_d   = wr_val;
                act_v_d = 1'b1;
            end else begin
                nxt_d   = wr_val;
                nxt_v_d = 1'b1;
            end
        end
        if (clr_all) begin
            act_v_d = 1'b0;
            nxt_v_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_v   <= 1'b0;
            nxt_v   <= 1'b0;
            act_val <= '0;
            nxt_val <= '0;
        end else begin
            act_v   <= act_v_d;
            nxt_v   <= nxt_v_d;
            act_val <= act_d;
            nxt_val <= nxt_d;
        end
    end

    // A queued value takes over on the match edge (R10).
    p_chain_r10: assert property (@(posedge clk) disable iff (rst)
        (hit && nxt_v && !clr_all) |=> (act_v && act_val == $past(nxt_val)));

    // The next buffer is only ever filled behind an armed value (R9).
    p_pend_needs_act_r9: assert property (@(posedge clk) disable iff (rst)
        nxt_v |-> act_v);

endmodule

// File: rtl/cmpch_pin.sv
module cmpch_pin
    import cmpch_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic [3:0] mode,
    input  logic       clr_all,
    output logic       pin
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic             tog;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            tog <= 1'b0;
            cnt <= '0;
        end else begin
            if (hit && mode == MODE_TOGGLE) tog <= ~tog;
            if (hit && mode == MODE_PULSE) cnt <= CNT_W'(PULSE_LEN);
            else if (cnt != '0)            cnt <= cnt - 1'b1;
        end
    end

    assign pin = tog | (cnt != '0);

    // Toggle-mode match flips the level (R6).
    p_toggle_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == MODE_TOGGLE && !clr_all) |=> (tog != $past(tog)));

    // Pulse counter stays inside its window (R7).
    p_pulse_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PULSE_LEN));

endmodule

// File: rtl/cmp_chan_top.sv
module cmp_chan_top
    import cmpch_pkg::*;
#(
    parameter int CTR_W     = 31,
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTR_W-1:0]  ctr_val,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] cmp_wdata,
    output logic [CTR_W-1:0]  cmp_rdata,
    output logic              irq,
    output logic              pin_out
);

    csr_t             csr_q;
    logic             clr_all;
    logic             hit;
    logic [CTR_W-1:0] cmp_masked;

    assign cmp_masked = cmp_wdata[CTR_W-1:0];

    generate
        if (DATA_W > CTR_W) begin : g_drop_hi
            logic unused_hi;
            assign unused_hi = ^cmp_wdata[DATA_W-1:CTR_W];
        end
    endgenerate

    cmpch_csr u_csr (
        .clk     (clk),
        .rst     (rst),
        .we      (csr_we),
        .wdata   (csr_wdata),
        .hit     (hit),
        .q       (csr_q),
        .clr_all (clr_all)
    );

    cmpch_slots #(.CTR_W(CTR_W)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .ctr     (ctr_val),
        .mode    (csr_q.mode),
        .wr_en   (cmp_we),
        .wr_val  (cmp_masked),
        .clr_all (clr_all),
        .hit     (hit),
        .act_val (cmp_rdata)
    );

    cmpch_pin #(.PULSE_LEN(PULSE_LEN)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .mode    (csr_q.mode),
        .clr_all (clr_all),
        .pin     (pin_out)
    );

    assign csr_rdata = csr_q;
    assign irq       = csr_q.flag & csr_q.ie;

endmodule

// File: tb/sim_cmp_chan_top.sv
module sim_cmp_chan_top;

    localparam int CW = 8;
    localparam int PL = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] ctr = '0;
    logic          csr_we = 1'b0;
    logic [7:0]    csr_wdata = '0;
    logic [7:0]    csr_rdata;
    logic          cmp_we = 1'b0;
    logic [31:0]   cmp_wdata = '0;
    logic [CW-1:0] cmp_rdata;
    logic          irq, pin_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cmp_chan_top #(.CTR_W(CW), .DATA_W(32), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst(rst), .ctr_val(ctr),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata),
        .irq(irq), .pin_out(pin_out)
    );

    // {start[8], compare[32], mode[4], pad[3], ie[1]}
    localparam logic [47:0] VECS [5] = '{
        {8'd10,  32'd20,    4'h5, 3'b0, 1'b1},
        {8'd250, 32'd3,     4'hF, 3'b0, 1'b1},
        {8'd0,   32'd255,   4'h5, 3'b0, 1'b0},
        {8'd100, 32'd101,   4'hF, 3'b0, 1'b0},
        {8'd40,  32'h12C,   4'h5, 3'b0, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        ctr = ctr + 1'b1;
    endtask

    task automatic wr_csr(input logic [7:0] d);
        csr_we = 1'b1; csr_wdata = d;
        @(posedge clk); #1;
        csr_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [31:0] d);
        cmp_we = 1'b1; cmp_wdata = d;
        @(posedge clk); #1;
        cmp_we = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check("R1", "csr", {24'd0, csr_rdata}, 32'h00);
        check("R1", "irq", {31'd0, irq}, 32'd0);
        check("R1", "pin", {31'd0, pin_out}, 32'd0);
        ctr = 8'd0;
        wr_csr(8'h14);
        repeat (3) tick();
        check("R1", "no armed value", {24'd0, csr_rdata}, 32'h14);

        // Vector table walk: R3, R5, R6, R7, R9, R11
        for (int i = 0; i < 5; i++) begin
            logic [47:0] v;
            logic [7:0]  st, d8;
            logic [31:0] cv;
            logic [3:0]  md;
            logic        ie;
            v  = VECS[i];
            st = v[47:40]; cv = v[39:8]; md = v[7:4]; ie = v[0];
            d8 = cv[7:0] - st;
            wr_csr(8'h00);
            wr_csr(8'h80);
            check("R4", "flag cleared", {24'd0, csr_rdata}, 32'h00);
            ctr = st;
            wr_csr({1'b0, ie, md, 2'b00});
            wr_cmp(cv);
            check("R9", "masked active", {24'd0, cmp_rdata}, {24'd0, cv[7:0]});
            repeat (int'(d8)) tick();
            check(i == 1 ? "R11" : "R3", "flag before match", {31'd0, csr_rdata[7]}, 32'd0);
            tick();
            check(i == 1 ? "R11" : "R3", "flag after match", {31'd0, csr_rdata[7]}, 32'd1);
            check("R5", "irq", {31'd0, irq}, {31'd0, ie});
            check(md == 4'h5 ? "R6" : "R7", "pin", {31'd0, pin_out}, 32'd1);
        end

        // R4: zero in bit 7 keeps the flag, one clears it
        wr_csr(8'h54);
        check("R4", "flag kept", {24'd0, csr_rdata}, 32'hD4);
        wr_csr(8'hD4);
        check("R4", "flag cleared by one", {24'd0, csr_rdata}, 32'h54);
        check("R5", "irq low", {31'd0, irq}, 32'd0);

        // R2: request bit stored, bit 1 reads zero
        wr_csr(8'h55);
        check("R2", "req readback", {24'd0, csr_rdata}, 32'h55);
        wr_csr(8'h56);
        check("R2", "bit1 zero", {24'd0, csr_rdata}, 32'h54);

        // R7: pulse width
        wr_csr(8'h00); wr_csr(8'h80);
        ctr = 8'd0;
        wr_csr(8'h3C);
        wr_cmp(32'd2);
        repeat (3) tick();
        check("R7", "pulse start", {31'd0, pin_out}, 32'd1);
        repeat (PL - 1) tick();
        check("R7", "pulse last", {31'd0, pin_out}, 32'd1);
        tick();
        check("R7", "pulse end", {31'd0, pin_out}, 32'd0);

        // R10: queued value chains
        wr_csr(8'h00); wr_csr(8'h80);
        ctr = 8'd0;
        wr_csr(8'h14);
        wr_cmp(32'd5);
        wr_cmp(32'd9);
        check("R9", "first stays active", {24'd0, cmp_rdata}, 32'd5);
        repeat (6) tick();
        check("R10", "first match", {31'd0, csr_rdata[7]}, 32'd1);
        check("R10", "promoted", {24'd0, cmp_rdata}, 32'd9);
        check("R6", "pin up", {31'd0, pin_out}, 32'd1);
        wr_csr(8'h94);
        repeat (3) tick();
        check("R10", "before second", {31'd0, csr_rdata[7]}, 32'd0);
        tick();
        check("R10", "second match", {31'd0, csr_rdata[7]}, 32'd1);
        check("R6", "pin down", {31'd0, pin_out}, 32'd0);

        // R12: zero write discards both values
        wr_csr(8'h00); wr_csr(8'h80);
        wr_csr(8'h14);
        ctr = 8'd0;
        wr_cmp(32'd5);
        wr_cmp(32'd9);
        wr_csr(8'h00);
        check("R2", "mode reads zero", {24'd0, csr_rdata}, 32'h00);
        wr_csr(8'h14);
        wr_cmp(32'd7);
        check("R12", "fresh active", {24'd0, cmp_rdata}, 32'd7);
        repeat (7) tick();
        check("R12", "old value gone", {31'd0, csr_rdata[7]}, 32'd0);
        tick();
        check("R12", "new match", {31'd0, csr_rdata[7]}, 32'd1);
        check("R6", "pin up", {31'd0, pin_out}, 32'd1);
        wr_csr(8'h00);
        check("R12", "pin forced low", {31'd0, pin_out}, 32'd0);

        // R8: disabled and unsupported modes
        wr_csr(8'h80);
        ctr = 8'd0;
        wr_cmp(32'd3);
        repeat (6) tick();
        check("R8", "mode0 flag", {31'd0, csr_rdata[7]}, 32'd0);
        check("R8", "mode0 pin", {31'd0, pin_out}, 32'd0);
        wr_csr(8'h0C);
        ctr = 8'd0;
        repeat (6) tick();
        check("R8", "mode3 flag", {31'd0, csr_rdata[7]}, 32'd0);
        check("R8", "mode3 pin", {31'd0, pin_out}, 32'd0);
        wr_csr(8'h14);
        ctr = 8'd0;
        repeat (4) tick();
        check("R8", "value stayed armed", {31'd0, csr_rdata[7]}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule